// File: doc/BRIEF.md
# Cascadable Static LCD Segment Driver

This block drives a 40-segment static LCD glass. Display bits arrive one at a time on a serial data input, paced by a data clock. They collect in a 40-stage shift chain. A load input then copies the whole chain into a display register, and that register decides which segments are lit. The last stage of the chain is brought out as a serial output. Several drivers can therefore be chained, with each one's serial output feeding the next one's serial input, and all of them share the load and clock lines.

A display clock input sets the drive frequency. Each rising edge of it flips a backplane phase. The two common outputs carry that phase as a 50% square wave. A lit segment is driven opposite to the common and an unlit segment is driven with it, so no segment sees a DC voltage.

Two active-low group enables switch off the lower 16 and the upper 24 segments. Each common has its own active-low enable. An active-low blink enable, together with an external blink clock, blanks the whole display while the blink clock is high.

All inputs are sampled on `clk`. The data clock and the display clock act on their rising edges, which are detected inside the block. The load, the enables and the blink clock act on their sampled levels.

Top module: `staticLcdDriver`

## Requirements
- R1: After reset, `segOut`, `comAOut`, `comBOut` and `serOut` are all 0, and the backplane phase is 0.
- R2: Each rising edge of `dataClk` shifts the chain by one place toward bit 39 and enters `serIn` at bit 0. After 40 edges, the first bit entered sits at bit 39, which drives segment `segOut[39]`. The last bit entered sits at bit 0, which drives `segOut[0]`.
- R3: `serOut` always shows chain bit 39. After one more `dataClk` edge, it shows the bit that was entered 39 edges earlier.
- R4: While `loadIn` is low, the segment pattern does not change, even when the chain shifts. While `loadIn` is high, the display register takes the chain contents.
- R5: Each rising edge of `dispClk` inverts the backplane phase. A `dispClk` held high or low leaves the phase unchanged.
- R6: With its group enabled and no blanking, a segment whose display bit is 1 outputs the inverse of the phase. A segment whose bit is 0 outputs the phase.
- R7: When `segLoEnN` is 1, `segOut[15:0]` equal the phase. When `segHiEnN` is 1, `segOut[39:16]` equal the phase. Each enable leaves the other group alone.
- R8: When `comAEnN` is 0, `comAOut` equals the phase, and when it is 1, `comAOut` is held at 0. `comBEnN` and `comBOut` behave the same way.
- R9: When `blinkEnN` is 0 and `blinkClk` is 1, every segment equals the phase. When `blinkClk` is 0, the stored pattern shows. When `blinkEnN` is 1, `blinkClk` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; every input is sampled on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| serIn | input | 1 | Serial display data |
| dataClk | input | 1 | Data clock; a rising edge shifts the chain |
| loadIn | input | 1 | High level copies the chain into the display register |
| blinkEnN | input | 1 | Blink enable, active low |
| blinkClk | input | 1 | Blink clock; high level blanks the display while blink is enabled |
| dispClk | input | 1 | Display clock; a rising edge flips the backplane phase |
| segLoEnN | input | 1 | Enable for segments 0 to 15, active low |
| segHiEnN | input | 1 | Enable for segments 16 to 39, active low |
| comAEnN | input | 1 | Enable for common A, active low |
| comBEnN | input | 1 | Enable for common B, active low |
| segOut | output | 40 | Segment drive lines |
| comAOut | output | 1 | Common A backplane |
| comBOut | output | 1 | Common B backplane |
| serOut | output | 1 | Cascade output, chain bit 39 |

## Verification
The bench checks the bit order of the chain. A design that shifted the wrong way would show the word mirrored and put the wrong bit on the cascade output. The bench shifts a new word while the load is low and checks that the old pattern stays on the glass; a design that let the chain reach the display early would fail here. It checks the group boundary between segments 15 and 16 with each enable turned off on its own, which catches an off-by-one split. It holds the display clock high over many cycles, which catches a phase that follows the level instead of the edge. It also raises the blink clock with blink disabled, which catches a blanking path that ignores the enable.

// File: rtl/lcdDrvPkg.sv
package lcdDrvPkg;

  // Strobes and levels passed from control to datapath
  typedef struct packed {
    logic shiftPulse;  // one-cycle pulse per data clock rising edge
    logic serBit;      // sampled serial input, aligned with shiftPulse
    logic loadLevel;   // sampled load level
    logic blankSeg;    // blanking active (blink enabled and blink clock high)
    logic phase;       // current backplane phase
    logic loEn;        // low segment group enabled
    logic hiEn;        // high segment group enabled
  } lcdCtrl_t;

endpackage

// File: rtl/lcdDrvCtrl.sv
module lcdDrvCtrl
  import lcdDrvPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     serIn,
  input  logic     dataClk,
  input  logic     loadIn,
  input  logic     blinkEnN,
  input  logic     blinkClk,
  input  logic     dispClk,
  input  logic     segLoEnN,
  input  logic     segHiEnN,
  input  logic     comAEnN,
  input  logic     comBEnN,
  output lcdCtrl_t strobes,
  output logic     comAOut,
  output logic     comBOut
);

  // sampled inputs
  logic serInS, dataClkS, loadS, blinkEnNS, blinkClkS, dispClkS;
  logic segLoEnNS, segHiEnNS, comAEnNS, comBEnNS;
  // edge history
  logic dataClkD, dispClkD;
  logic phase;
  logic dataEdge, dispEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serInS    <= 1'b0;
      dataClkS  <= 1'b0;
      loadS     <= 1'b0;
      blinkEnNS <= 1'b1;
      blinkClkS <= 1'b0;
      dispClkS  <= 1'b0;
      segLoEnNS <= 1'b1;
      segHiEnNS <= 1'b1;
      comAEnNS  <= 1'b1;
      comBEnNS  <= 1'b1;
    end else begin
      serInS    <= serIn;
      dataClkS  <= dataClk;
      loadS     <= loadIn;
      blinkEnNS <= blinkEnN;
      blinkClkS <= blinkClk;
      dispClkS  <= dispClk;
      segLoEnNS <= segLoEnN;
      segHiEnNS <= segHiEnN;
      comAEnNS  <= comAEnN;
      comBEnNS  <= comBEnN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataClkD <= 1'b0;
      dispClkD <= 1'b0;
    end else begin
      dataClkD <= dataClkS;
      dispClkD <= dispClkS;
    end
  end

  assign dataEdge = dataClkS & ~dataClkD;
  assign dispEdge = dispClkS & ~dispClkD;

  // backplane phase: one inversion per display clock rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         phase <= 1'b0;
    else if (dispEdge) phase <= ~phase;
  end

  always_comb begin
    strobes.shiftPulse = dataEdge;
    strobes.serBit     = serInS;
    strobes.loadLevel  = loadS;
    strobes.blankSeg   = ~blinkEnNS & blinkClkS;
    strobes.phase      = phase;
    strobes.loEn       = ~segLoEnNS;
    strobes.hiEn       = ~segHiEnNS;
  end

  assign comAOut = ~comAEnNS & phase;
  assign comBOut = ~comBEnNS & phase;

  // R5
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dispEdge |=> $stable(phase));

  // R5
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispEdge |=> (phase != $past(phase)));

  // R8
  com_a_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    comAEnNS |-> !comAOut);

  // R8
  com_b_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    comBEnNS |-> !comBOut);

endmodule

// File: rtl/lcdDrvPath.sv
module lcdDrvPath
  import lcdDrvPkg::*;
#(
  parameter int SEG_COUNT = 40,
  parameter int LO_GROUP  = 16
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  lcdCtrl_t             strobes,
  output logic [SEG_COUNT-1:0] segOut,
  output logic                 serOut
);

  localparam int TOP = SEG_COUNT - 1;

  logic [TOP:0] shiftReg;
  logic [TOP:0] dispReg;

  // serial chain: new bit enters at bit 0, oldest leaves at the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   shiftReg <= '0;
    else if (strobes.shiftPulse) shiftReg <= {shiftReg[TOP-1:0], strobes.serBit};
  end

  // display register follows the chain only while load is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  dispReg <= '0;
    else if (strobes.loadLevel) dispReg <= shiftReg;
  end

  assign serOut = shiftReg[TOP];

  // per-segment drive, group enable chosen by position
  for (genvar i = 0; i < SEG_COUNT; i++) begin : gSeg
    localparam bit IN_LO = (i < LO_GROUP);
    logic groupEn;
    if (IN_LO) begin : gLo
      assign groupEn = strobes.loEn;
    end else begin : gHi
      assign groupEn = strobes.hiEn;
    end
    assign segOut[i] = strobes.phase ^ (dispReg[i] & groupEn & ~strobes.blankSeg);
  end

  // R3
  ser_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftPulse |=> (serOut == $past(shiftReg[TOP-1])));

  // R2
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shiftPulse |=> $stable(shiftReg));

  // R4
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadLevel |=> $stable(dispReg));

  // R9
  blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.blankSeg |-> (segOut == {SEG_COUNT{strobes.phase}}));

endmodule

// File: rtl/staticLcdDriver.sv
module staticLcdDriver
  import lcdDrvPkg::*;
#(
  parameter int SEG_COUNT = 40,
  parameter int LO_GROUP  = 16
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serIn,
  input  logic                 dataClk,
  input  logic                 loadIn,
  input  logic                 blinkEnN,
  input  logic                 blinkClk,
  input  logic                 dispClk,
  input  logic                 segLoEnN,
  input  logic                 segHiEnN,
  input  logic                 comAEnN,
  input  logic                 comBEnN,
  output logic [SEG_COUNT-1:0] segOut,
  output logic                 comAOut,
  output logic                 comBOut,
  output logic                 serOut
);

  lcdCtrl_t strobes;

  lcdDrvCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .serIn    (serIn),
    .dataClk  (dataClk),
    .loadIn   (loadIn),
    .blinkEnN (blinkEnN),
    .blinkClk (blinkClk),
    .dispClk  (dispClk),
    .segLoEnN (segLoEnN),
    .segHiEnN (segHiEnN),
    .comAEnN  (comAEnN),
    .comBEnN  (comBEnN),
    .strobes  (strobes),
    .comAOut  (comAOut),
    .comBOut  (comBOut)
  );

  lcdDrvPath #(
    .SEG_COUNT (SEG_COUNT),
    .LO_GROUP  (LO_GROUP)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .segOut  (segOut),
    .serOut  (serOut)
  );

endmodule

// File: tb/staticLcdDriver_test.sv
`timescale 1ns/1ps
module staticLcdDriver_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serIn = 1'b0, dataClk = 1'b0, loadIn = 1'b0;
  logic        blinkEnN = 1'b1, blinkClk = 1'b0, dispClk = 1'b0;
  logic        segLoEnN = 1'b1, segHiEnN = 1'b1, comAEnN = 1'b1, comBEnN = 1'b1;
  logic [39:0] segOut;
  logic        comAOut, comBOut, serOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic ph = 1'b0;  // expected backplane phase

  always #4 clk = ~clk;

  staticLcdDriver uut (
    .clk(clk), .rstN(rstN), .serIn(serIn), .dataClk(dataClk), .loadIn(loadIn),
    .blinkEnN(blinkEnN), .blinkClk(blinkClk), .dispClk(dispClk),
    .segLoEnN(segLoEnN), .segHiEnN(segHiEnN), .comAEnN(comAEnN), .comBEnN(comBEnN),
    .segOut(segOut), .comAOut(comAOut), .comBOut(comBOut), .serOut(serOut)
  );

  // vector: {word[39:0], loEnN, hiEnN, blinkEnN, blinkClk}
  localparam logic [43:0] VECS [6] = '{
    {40'hF0F0_1234_AB, 4'b0010},  // R6 all enabled
    {40'hFF_FFFF_FFFF, 4'b1010},  // R7 low group off
    {40'hFF_FFFF_FFFF, 4'b0110},  // R7 high group off
    {40'h12_3456_789A, 4'b0001},  // R9 blanked
    {40'h12_3456_789A, 4'b0000},  // R9 blink clock low shows data
    {40'h12_3456_789A, 4'b0011}   // R9 blink disabled ignores blink clock
  };

  function automatic logic [39:0] expSeg(input logic [39:0] w, input logic loN,
                                         input logic hiN, input logic bEnN,
                                         input logic bClk, input logic p);
    logic [39:0] mask;
    mask = {{24{~hiN}}, {16{~loN}}};
    if (!bEnN && bClk) mask = '0;
    return {40{p}} ^ (w & mask);
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pushBit(input logic b);
    serIn = b; dataClk = 1'b1; waitClk(2);
    dataClk = 1'b0; waitClk(2);
  endtask

  task automatic shiftWord(input logic [39:0] w);
    for (int i = 39; i >= 0; i--) pushBit(w[i]);
  endtask

  task automatic loadPulse();
    loadIn = 1'b1; waitClk(3);
    loadIn = 1'b0; waitClk(3);
  endtask

  task automatic dispTick();
    dispClk = 1'b1; waitClk(3);
    dispClk = 1'b0; waitClk(3);
    ph = ~ph;
  endtask

  initial begin
    waitClk(3);
    // R1 reset state
    check("R1 seg", {24'd0, segOut}, 64'd0);
    check("R1 com", {62'd0, comAOut, comBOut}, 64'd0);
    check("R1 ser", {63'd0, serOut}, 64'd0);
    rstN = 1'b1;
    segLoEnN = 1'b0; segHiEnN = 1'b0; comAEnN = 1'b0; comBEnN = 1'b0;
    waitClk(3);
    check("R1 phase0", {62'd0, comAOut, comBOut}, 64'd0);

    // table walk
    for (int v = 0; v < 6; v++) begin
      logic [39:0] w;
      w = VECS[v][43:4];
      shiftWord(w);
      loadPulse();
      segLoEnN = VECS[v][3]; segHiEnN = VECS[v][2];
      blinkEnN = VECS[v][1]; blinkClk = VECS[v][0];
      waitClk(3);
      check("R6/R7/R9 table", {24'd0, segOut},
            {24'd0, expSeg(w, VECS[v][3], VECS[v][2], VECS[v][1], VECS[v][0], ph)});
      dispTick();
      check("R5/R6 table flipped", {24'd0, segOut},
            {24'd0, expSeg(w, VECS[v][3], VECS[v][2], VECS[v][1], VECS[v][0], ph)});
    end
    segLoEnN = 1'b0; segHiEnN = 1'b0; blinkEnN = 1'b1; blinkClk = 1'b0;

    // R2 bit order: first bit entered lands on segment 39
    shiftWord(40'h80_0000_0001);
    loadPulse();
    check("R2 order", {24'd0, segOut}, {24'd0, {40{ph}} ^ 40'h80_0000_0001});
    // R3 cascade output
    check("R3 serOut top", {63'd0, serOut}, 64'd1);
    pushBit(1'b0);
    check("R3 serOut next", {63'd0, serOut}, 64'd0);

    // R4 display held while load low
    shiftWord(40'h0F_0F0F_0F0F);
    loadPulse();
    shiftWord(40'hAA_AAAA_AAAA);
    check("R4 hold", {24'd0, segOut}, {24'd0, {40{ph}} ^ 40'h0F_0F0F_0F0F});
    loadPulse();
    check("R4 load", {24'd0, segOut}, {24'd0, {40{ph}} ^ 40'hAA_AAAA_AAAA});

    // R5 level held high: one flip only
    dispClk = 1'b1; waitClk(20);
    ph = ~ph;
    check("R5 held high", {63'd0, comAOut}, {63'd0, ph});
    dispClk = 1'b0; waitClk(20);
    check("R5 fall no flip", {63'd0, comAOut}, {63'd0, ph});

    // R8 common enables
    if (!ph) dispTick();
    check("R8 both on", {62'd0, comAOut, comBOut}, 64'd3);
    comAEnN = 1'b1; waitClk(3);
    check("R8 A off", {62'd0, comAOut, comBOut}, 64'd1);
    comAEnN = 1'b0; comBEnN = 1'b1; waitClk(3);
    check("R8 B off", {62'd0, comAOut, comBOut}, 64'd2);
    comBEnN = 1'b0; waitClk(3);

    // R7 boundary between segment 15 and 16
    shiftWord(40'h00_0001_8000);
    loadPulse();
    segLoEnN = 1'b1; waitClk(3);
    check("R7 bit16 kept", {24'd0, segOut}, {24'd0, {40{ph}} ^ 40'h00_0001_0000});
    segLoEnN = 1'b0; segHiEnN = 1'b1; waitClk(3);
    check("R7 bit15 kept", {24'd0, segOut}, {24'd0, {40{ph}} ^ 40'h00_0000_8000});
    segHiEnN = 1'b0; waitClk(3);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule